// File: doc/BRIEF.md
# USB IN Endpoint Double Packet Buffer

This block holds the transmit data of one USB IN endpoint in two packet slots and gives the CPU a single 8-bit control and status register for that endpoint. The CPU loads packet bytes one at a time through a byte write port. It commits a packet either by writing the packet-ready bit or by letting the hardware commit it once the byte count reaches the configured maximum packet size. Up to two committed packets wait in arrival order.

The bus side presents IN tokens. For each token the block answers with exactly one one-cycle response: data, STALL, zero-length (isochronous underrun) or NAK. When it answers with data, the bus engine reads the oldest packet byte by byte, using the length the block reports. It then reports either successful delivery, which releases the slot, or a failed attempt, which keeps the packet for a retry. A flush command drops the oldest committed packet. With no packet committed, a flush discards the bytes written so far.

Top module: `usb_in_txbuf`

## Requirements
- R1: After reset the register reads 0x00 and no response output is asserted.
- R2: Each byte write is stored in the slot being filled. The not-empty bit (bit 5) reads 1 once any byte is written or any packet is committed. It reads 0 otherwise.
- R3: Writing 1 to the packet-ready bit (bit 0) commits the bytes written so far as a packet, and bit 0 then reads 1. Writing 0 to bit 0 has no effect.
- R4: With auto-commit (bit 7) set, the byte write that brings the byte count to the maximum packet size commits the packet in that same cycle.
- R5: At most two packets are committed. While two are held, byte writes and commit requests are ignored.
- R6: An IN token that arrives while at least one packet is committed, with stall clear, produces a one-cycle data response on the next cycle. The reported length is then that of the oldest packet, and its bytes are read in write order, advancing on each read strobe.
- R7: A delivery-done indication during a transmission releases the oldest packet, so the next token serves the next packet. Packet-ready returns to 0 when both slots are empty.
- R8: A failed-attempt indication ends the transmission without releasing the packet, and the next token sends the same packet again from its first byte.
- R9: Writing 1 to the flush bit (bit 6) while idle drops only the oldest committed packet. With none committed, it discards the partly written bytes. Bit 6 always reads 0.
- R10: A flush request made during a transmission has no effect.
- R11: While the stall bit (bit 2) is set, every IN token gets a one-cycle STALL response and no data response, and the committed packets stay queued.
- R12: A token that finds no packet committed gets a zero-length response if the isochronous bit (bit 3) is set, which also sets the underrun flag (bit 1). If bit 3 is clear, the token gets a NAK response and the flag is unchanged.
- R13: The underrun flag is cleared only by writing 0 to bit 1, and writing 1 there has no effect. The rate-feedback bit (bit 4) is plain read/write storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuByteWr | input | 1 | Byte write strobe into the slot being filled |
| cpuByte | input | 8 | Byte to store |
| regWr | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write value |
| regRdData | output | 8 | Control register read value |
| maxPktSize | input | 7 | Maximum packet size in bytes for auto-commit |
| inToken | input | 1 | IN token arrived for this endpoint |
| txRdEn | input | 1 | Advance to the next byte of the packet being sent |
| txRdData | output | 8 | Current byte of the packet being sent |
| txLen | output | 7 | Length of the oldest committed packet |
| txDone | input | 1 | Packet delivered and acknowledged |
| txFail | input | 1 | Transmission attempt failed; keep the packet |
| respData | output | 1 | One-cycle data response |
| respStall | output | 1 | One-cycle STALL response |
| respZero | output | 1 | One-cycle zero-length response |
| respNak | output | 1 | One-cycle NAK response |

## Verification
The assertions check several properties on every cycle. The committed count never exceeds two, and a transmission is active only while a packet is held. At most one response is given per cycle, and a stalled token always yields a STALL response. An isochronous token with nothing queued always sets the underrun flag, and packet-ready falls only after a delivery or a flush. Only the bench scenarios can show the rest of the behaviour. These are the byte order and lengths of the data, that the oldest packet is the one selected on flush and on delivery, that retries replay from the first byte, and that writes are ignored when both slots are full or during a transmission.

// File: rtl/usb_in_txbuf_pkg.sv
package usb_in_txbuf_pkg;
  // register bit positions
  localparam int unsigned BIT_RDY   = 0;
  localparam int unsigned BIT_URUN  = 1;
  localparam int unsigned BIT_STALL = 2;
  localparam int unsigned BIT_ISO   = 3;
  localparam int unsigned BIT_RATE  = 4;
  localparam int unsigned BIT_NEMP  = 5;
  localparam int unsigned BIT_FLUSH = 6;
  localparam int unsigned BIT_AUTO  = 7;

  // strobes from control to datapath
  typedef struct packed {
    logic wrByte;      // store a byte into the fill slot
    logic commit;      // latch fill count as packet length
    logic fillSlot;    // slot index being filled
    logic headSlot;    // slot index of the oldest packet
    logic txStart;     // rewind the read pointer
    logic rdByte;      // advance the read pointer
    logic clrPartial;  // discard partly written bytes
  } txStrobe_t;
endpackage

// File: rtl/usb_in_txbuf_data.sv
module usb_in_txbuf_data
  import usb_in_txbuf_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PKT_DEPTH = 64,
  localparam int unsigned LEN_W    = $clog2(PKT_DEPTH + 1),
  localparam int unsigned PTR_W    = $clog2(PKT_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [LEN_W-1:0]  fillCnt,
  output logic [LEN_W-1:0]  headLen,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(PKT_DEPTH);

  logic [LEN_W-1:0]  rdPtr;
  logic              roomLeft;
  logic              storeByte;
  logic [LEN_W-1:0]  commitLen;
  logic [LEN_W-1:0]  slotLen  [2];
  logic [DATA_W-1:0] slotByte [2];

  assign roomLeft  = fillCnt < DEPTH_L;
  assign storeByte = strb.wrByte && roomLeft;
  assign commitLen = fillCnt + LEN_W'(storeByte);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt <= '0;
    end else if (strb.clrPartial || strb.commit) begin
      fillCnt <= '0;
    end else if (storeByte) begin
      fillCnt <= fillCnt + 1'b1;
    end
  end

  for (genvar s = 0; s < 2; s++) begin : g_slot
    logic [DATA_W-1:0] mem [PKT_DEPTH];
    logic              selFill;
    assign selFill = (strb.fillSlot == 1'(s));

    always_ff @(posedge clk) begin
      if (storeByte && selFill) begin
        mem[fillCnt[PTR_W-1:0]] <= wrData;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotLen[s] <= '0;
      end else if (strb.commit && selFill) begin
        slotLen[s] <= commitLen;
      end
    end

    assign slotByte[s] = mem[rdPtr[PTR_W-1:0]];
  end

  assign headLen = slotLen[strb.headSlot];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
    end else if (strb.txStart) begin
      rdPtr <= '0;
    end else if (strb.rdByte && (rdPtr < headLen)) begin
      rdPtr <= rdPtr + 1'b1;
    end
  end

  assign rdData = (rdPtr < headLen) ? slotByte[strb.headSlot] : '0;
endmodule

// File: rtl/usb_in_txbuf_ctrl.sv
module usb_in_txbuf_ctrl
  import usb_in_txbuf_pkg::*;
#(
  parameter int unsigned PKT_DEPTH = 64,
  localparam int unsigned LEN_W    = $clog2(PKT_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuByteWr,
  input  logic             regWr,
  input  logic [7:0]       regWrData,
  output logic [7:0]       regRdData,
  input  logic [LEN_W-1:0] maxPktSize,
  input  logic [LEN_W-1:0] fillCnt,
  input  logic             inToken,
  input  logic             txRdEn,
  input  logic             txDone,
  input  logic             txFail,
  output txStrobe_t        strb,
  output logic [1:0]       pktCnt,
  output logic             txBusy,
  output logic             respData,
  output logic             respStall,
  output logic             respZero,
  output logic             respNak
);
  localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(PKT_DEPTH);

  logic head;
  logic stallEn, isoEn, rateEn, autoEn, urunFlag;
  logic full, anyPkt, byteOk, autoFire, manCommit, commit;
  logic tokIdle, txStart, doneOk, failOk;
  logic flushReq, flushPop, flushPart, pop;

  assign full      = (pktCnt == 2'd2);
  assign anyPkt    = (pktCnt != 2'd0);
  assign byteOk    = cpuByteWr && !full;
  assign autoFire  = autoEn && byteOk && (fillCnt < DEPTH_L)
                     && ((fillCnt + 1'b1) == maxPktSize);
  assign manCommit = regWr && regWrData[BIT_RDY];
  assign commit    = (manCommit || autoFire) && !full;

  assign tokIdle   = inToken && !txBusy;
  assign txStart   = tokIdle && !stallEn && anyPkt;
  assign doneOk    = txDone && txBusy;
  assign failOk    = txFail && txBusy && !txDone;

  assign flushReq  = regWr && regWrData[BIT_FLUSH];
  assign flushPop  = flushReq && !txBusy && !txStart && anyPkt;
  assign flushPart = flushReq && !txBusy && !anyPkt;
  assign pop       = doneOk || flushPop;

  always_comb begin
    strb            = '0;
    strb.wrByte     = byteOk && !flushPart;
    strb.commit     = commit;
    strb.fillSlot   = head ^ (pktCnt == 2'd1);
    strb.headSlot   = head;
    strb.txStart    = txStart;
    strb.rdByte     = txRdEn && txBusy;
    strb.clrPartial = flushPart;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktCnt <= '0;
      head   <= 1'b0;
    end else begin
      pktCnt <= pktCnt + 2'(commit) - 2'(pop);
      if (pop) head <= ~head;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy <= 1'b0;
    end else if (txStart) begin
      txBusy <= 1'b1;
    end else if (doneOk || failOk) begin
      txBusy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stallEn <= 1'b0;
      isoEn   <= 1'b0;
      rateEn  <= 1'b0;
      autoEn  <= 1'b0;
    end else if (regWr) begin
      stallEn <= regWrData[BIT_STALL];
      isoEn   <= regWrData[BIT_ISO];
      rateEn  <= regWrData[BIT_RATE];
      autoEn  <= regWrData[BIT_AUTO];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      urunFlag <= 1'b0;
    end else if (tokIdle && !stallEn && !anyPkt && isoEn) begin
      urunFlag <= 1'b1;
    end else if (regWr && !regWrData[BIT_URUN]) begin
      urunFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respData  <= 1'b0;
      respStall <= 1'b0;
      respZero  <= 1'b0;
      respNak   <= 1'b0;
    end else begin
      respData  <= txStart;
      respStall <= tokIdle && stallEn;
      respZero  <= tokIdle && !stallEn && !anyPkt && isoEn;
      respNak   <= tokIdle && !stallEn && !anyPkt && !isoEn;
    end
  end

  always_comb begin
    regRdData            = '0;
    regRdData[BIT_RDY]   = anyPkt;
    regRdData[BIT_URUN]  = urunFlag;
    regRdData[BIT_STALL] = stallEn;
    regRdData[BIT_ISO]   = isoEn;
    regRdData[BIT_RATE]  = rateEn;
    regRdData[BIT_NEMP]  = anyPkt || (fillCnt != '0);
    regRdData[BIT_FLUSH] = 1'b0;
    regRdData[BIT_AUTO]  = autoEn;
  end
endmodule

// File: rtl/usb_in_txbuf.sv
module usb_in_txbuf
  import usb_in_txbuf_pkg::*;
#(
  parameter int unsigned PKT_DEPTH = 64,
  localparam int unsigned LEN_W    = $clog2(PKT_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuByteWr,
  input  logic [7:0]       cpuByte,
  input  logic             regWr,
  input  logic [7:0]       regWrData,
  output logic [7:0]       regRdData,
  input  logic [LEN_W-1:0] maxPktSize,
  input  logic             inToken,
  input  logic             txRdEn,
  output logic [7:0]       txRdData,
  output logic [LEN_W-1:0] txLen,
  input  logic             txDone,
  input  logic             txFail,
  output logic             respData,
  output logic             respStall,
  output logic             respZero,
  output logic             respNak
);
  txStrobe_t        strb;
  logic [LEN_W-1:0] fillCnt;
  logic [1:0]       pktCnt;
  logic             txBusy;

  usb_in_txbuf_ctrl #(.PKT_DEPTH(PKT_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuByteWr(cpuByteWr), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData), .maxPktSize(maxPktSize),
    .fillCnt(fillCnt), .inToken(inToken), .txRdEn(txRdEn), .txDone(txDone),
    .txFail(txFail), .strb(strb), .pktCnt(pktCnt), .txBusy(txBusy),
    .respData(respData), .respStall(respStall), .respZero(respZero),
    .respNak(respNak)
  );

  usb_in_txbuf_data #(.DATA_W(8), .PKT_DEPTH(PKT_DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(cpuByte),
    .fillCnt(fillCnt), .headLen(txLen), .rdData(txRdData)
  );
endmodule

// File: rtl/usb_in_txbuf_checker.sv
module usb_in_txbuf_checker (
  input logic       clk,
  input logic       rstN,
  input logic       regWr,
  input logic [7:0] regWrData,
  input logic [7:0] regRdData,
  input logic       inToken,
  input logic       txDone,
  input logic [1:0] pktCnt,
  input logic       txBusy,
  input logic       respData,
  input logic       respStall,
  input logic       respZero,
  input logic       respNak
);
  // R5: never more than two committed packets
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    pktCnt <= 2'd2);

  // R6: a transmission only runs while a packet is held
  a_r6_busy_has_pkt: assert property (@(posedge clk) disable iff (!rstN)
    txBusy |-> (pktCnt != 2'd0));

  // R6, R11, R12: one response at a time
  a_r6_one_resp: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({respData, respStall, respZero, respNak}));

  // R11: stalled token yields STALL
  a_r11_stall_resp: assert property (@(posedge clk) disable iff (!rstN)
    (inToken && !txBusy && regRdData[2]) |=> (respStall && !respData));

  // R12: isochronous token with nothing queued flags underrun
  a_r12_iso_underrun: assert property (@(posedge clk) disable iff (!rstN)
    (inToken && !txBusy && !regRdData[2] && regRdData[3] && pktCnt == 2'd0)
      |=> (respZero && regRdData[1]));

  // R7, R9: packet-ready only falls after a delivery or a flush
  a_r7_rdy_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(regRdData[0]) |-> ($past(txDone && txBusy) || $past(regWr && regWrData[6])));
endmodule

bind usb_in_txbuf usb_in_txbuf_checker u_checker (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regWrData(regWrData),
  .regRdData(regRdData), .inToken(inToken), .txDone(txDone),
  .pktCnt(pktCnt), .txBusy(txBusy), .respData(respData),
  .respStall(respStall), .respZero(respZero), .respNak(respNak)
);

// File: tb/usb_in_txbuf_bench.sv
module usb_in_txbuf_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpuByteWr = 1'b0;
  logic [7:0] cpuByte = '0;
  logic       regWr = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [6:0] maxPktSize = 7'd4;
  logic       inToken = 1'b0;
  logic       txRdEn = 1'b0;
  logic [7:0] txRdData;
  logic [6:0] txLen;
  logic       txDone = 1'b0;
  logic       txFail = 1'b0;
  logic       respData, respStall, respZero, respNak;

  int nTests = 0;
  int nFail  = 0;
  logic [7:0] cfg = 8'h02; // writable settings shadow; bit1 kept 1 (no clear)

  usb_in_txbuf u_usb_in_txbuf (.*);

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrByte(input logic [7:0] d);
    @(negedge clk); cpuByteWr = 1'b1; cpuByte = d;
    @(negedge clk); cpuByteWr = 1'b0;
  endtask

  task automatic wrReg(input logic [7:0] d);
    @(negedge clk); regWr = 1'b1; regWrData = d;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic setCfg(input logic [7:0] d);
    cfg = d | 8'h02;
    wrReg(cfg);
  endtask

  task automatic commitPkt(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) wrByte(base + 8'(i));
    wrReg(cfg | 8'h01);
  endtask

  // token; returns responses sampled the cycle after
  task automatic token(output logic [3:0] r);
    @(negedge clk); inToken = 1'b1;
    @(negedge clk); inToken = 1'b0;
    r = {respData, respStall, respZero, respNak};
  endtask

  task automatic readPkt(input string req, input int n, input logic [7:0] base);
    check(txLen == 7'(n), req, int'(txLen), n);
    for (int i = 0; i < n; i++) begin
      check(txRdData == base + 8'(i), req, int'(txRdData), int'(base) + i);
      txRdEn = 1'b1;
      @(negedge clk); txRdEn = 1'b0;
    end
  endtask

  task automatic pulseDone();
    txDone = 1'b1; @(negedge clk); txDone = 1'b0;
  endtask

  task automatic tReset();
    check(regRdData == 8'h00, "R1", int'(regRdData), 0);
    check({respData, respStall, respZero, respNak} == 4'b0, "R1",
          int'({respData, respStall, respZero, respNak}), 0);
  endtask

  task automatic tEmptyTokens();
    logic [3:0] r;
    token(r);
    check(r == 4'b0001, "R12", int'(r), 1);
    check(regRdData[1] == 1'b0, "R12", int'(regRdData[1]), 0);
    setCfg(8'h08);
    token(r);
    check(r == 4'b0010, "R12", int'(r), 2);
    check(regRdData[1] == 1'b1, "R12", int'(regRdData[1]), 1);
    wrReg(cfg);
    check(regRdData[1] == 1'b1, "R13", int'(regRdData[1]), 1);
    wrReg(8'h10);
    check(regRdData[1] == 1'b0, "R13", int'(regRdData[1]), 0);
    check(regRdData[4] == 1'b1, "R13", int'(regRdData[4]), 1);
    setCfg(8'h00);
  endtask

  task automatic tManual();
    logic [3:0] r;
    wrByte(8'h31); wrByte(8'h32); wrByte(8'h33);
    check(regRdData[5] == 1'b1, "R2", int'(regRdData[5]), 1);
    check(regRdData[0] == 1'b0, "R2", int'(regRdData[0]), 0);
    wrReg(cfg);
    check(regRdData[0] == 1'b0, "R3", int'(regRdData[0]), 0);
    wrReg(cfg | 8'h01);
    check(regRdData[0] == 1'b1, "R3", int'(regRdData[0]), 1);
    token(r);
    check(r == 4'b1000, "R6", int'(r), 8);
    readPkt("R6", 3, 8'h31);
    pulseDone();
    check(regRdData[0] == 1'b0, "R7", int'(regRdData[0]), 0);
    check(regRdData[5] == 1'b0, "R7", int'(regRdData[5]), 0);
  endtask

  task automatic tTwoPkts();
    logic [3:0] r;
    commitPkt(2, 8'h50);
    commitPkt(4, 8'h60);
    wrByte(8'hEE);
    wrReg(cfg | 8'h01);
    token(r);
    check(r == 4'b1000, "R5", int'(r), 8);
    readPkt("R5", 2, 8'h50);
    pulseDone();
    check(regRdData[0] == 1'b1, "R7", int'(regRdData[0]), 1);
    token(r);
    check(r == 4'b1000, "R7", int'(r), 8);
    readPkt("R7", 4, 8'h60);
    pulseDone();
    check(regRdData[0] == 1'b0, "R5", int'(regRdData[0]), 0);
    check(regRdData[5] == 1'b0, "R5", int'(regRdData[5]), 0);
  endtask

  task automatic tAuto();
    logic [3:0] r;
    maxPktSize = 7'd4;
    setCfg(8'h80);
    wrByte(8'h70); wrByte(8'h71); wrByte(8'h72);
    check(regRdData[0] == 1'b0, "R4", int'(regRdData[0]), 0);
    wrByte(8'h73);
    check(regRdData[0] == 1'b1, "R4", int'(regRdData[0]), 1);
    setCfg(8'h00);
    token(r);
    check(r == 4'b1000, "R4", int'(r), 8);
    readPkt("R4", 4, 8'h70);
    pulseDone();
  endtask

  task automatic tRetry();
    logic [3:0] r;
    commitPkt(2, 8'h80);
    token(r);
    txRdEn = 1'b1; @(negedge clk); txRdEn = 1'b0;
    txFail = 1'b1; @(negedge clk); txFail = 1'b0;
    check(regRdData[0] == 1'b1, "R8", int'(regRdData[0]), 1);
    token(r);
    check(r == 4'b1000, "R8", int'(r), 8);
    readPkt("R8", 2, 8'h80);
    pulseDone();
  endtask

  task automatic tFlush();
    logic [3:0] r;
    commitPkt(1, 8'h90);
    commitPkt(2, 8'hA0);
    wrReg(cfg | 8'h40);
    check(regRdData[0] == 1'b1, "R9", int'(regRdData[0]), 1);
    check(regRdData[6] == 1'b0, "R9", int'(regRdData[6]), 0);
    token(r);
    readPkt("R9", 2, 8'hA0);
    pulseDone();
    commitPkt(3, 8'hB0);
    wrReg(cfg | 8'h40);
    check(regRdData[0] == 1'b0, "R9", int'(regRdData[0]), 0);
    wrByte(8'hC0);
    wrReg(cfg | 8'h40);
    check(regRdData[5] == 1'b0, "R9", int'(regRdData[5]), 0);
  endtask

  task automatic tFlushBusy();
    logic [3:0] r;
    commitPkt(2, 8'hD0);
    token(r);
    wrReg(cfg | 8'h40);
    check(regRdData[0] == 1'b1, "R10", int'(regRdData[0]), 1);
    readPkt("R10", 2, 8'hD0);
    pulseDone();
    check(regRdData[0] == 1'b0, "R10", int'(regRdData[0]), 0);
  endtask

  task automatic tStall();
    logic [3:0] r;
    commitPkt(1, 8'hE0);
    setCfg(8'h04);
    token(r);
    check(r == 4'b0100, "R11", int'(r), 4);
    check(regRdData[0] == 1'b1, "R11", int'(regRdData[0]), 1);
    setCfg(8'h00);
    token(r);
    check(r == 4'b1000, "R11", int'(r), 8);
    readPkt("R11", 1, 8'hE0);
    pulseDone();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tEmptyTokens();
    tManual();
    tTwoPkts();
    tAuto();
    tRetry();
    tFlush();
    tFlushBusy();
    tStall();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule